// File: doc/BRIEF.md
# Preamble Quality and Clear-Channel Qualifier

This block judges an incoming bit stream and the state of the channel, one recovered bit at a time. Its first half is a preamble quality estimator. It is a saturating score that climbs by one for every bit that differs from the bit before it, and drops by a larger fixed step for every bit that repeats. A strongly alternating preamble therefore drives the score up quickly, and random data or a steady level keeps it near zero. A flag reports when the score has reached a programmable level. A downstream sync-word searcher uses that flag as its enable. The score and its bit history are wiped whenever receive is entered or a sync word is found.

The second half is a clear-channel assessor. It folds a "signal strength below threshold" indication and a "packet in progress" indication into a single clear flag. One of four policies picks how it does this. The clear flag decides whether a transmit request raised while the radio is receiving is granted. Requests made outside receive pass straight through. The threshold and the policy sit in two small configuration registers that load on a write strobe.

Top module: `link_qualifier`

## Requirements
- R1: After reset and after every clear, the first valid bit is only stored as the previous bit. The score does not change on that bit.
- R2: A valid bit that differs from the stored previous bit raises the score by 1. The score saturates at 31.
- R3: A valid bit equal to the stored previous bit lowers the score by 8. The score floors at 0.
- R4: `quality_ok` is 1 exactly when the score is at least 4 times the threshold, so a threshold of 0 keeps it at 1.
- R5: `rx_start` or `sync_found` zeroes the score and forgets the previous bit on the next edge. This takes priority over a valid bit in the same cycle, and that bit is not counted.
- R6: `cfg_we` loads `cfg_thr` and `cfg_mode` at the clock edge. Reset gives threshold 0 and policy 3. With `cfg_we` at 0, both keep their values.
- R7: `chan_clear` follows the policy. Policy 0 is always clear. Policy 1 is clear when `rssi_low` is 1. Policy 2 is clear when `pkt_active` is 0. Policy 3 is clear when `rssi_low` is 1 and `pkt_active` is 0.
- R8: `tx_grant` equals `tx_req` when `in_rx` is 0. When `in_rx` is 1, it equals `tx_req` AND `chan_clear`.
- R9: With no valid bit and no clear, the score holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_start | input | 1 | Pulse on entry to receive; clears the estimator |
| sync_found | input | 1 | Pulse on sync-word detection; clears the estimator |
| bit_valid | input | 1 | Strobe marking a recovered bit |
| bit_in | input | 1 | Recovered bit |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_thr | input | 3 | Quality threshold to load |
| cfg_mode | input | 2 | Clear-channel policy to load |
| rssi_low | input | 1 | Signal strength is below its threshold |
| pkt_active | input | 1 | A packet is currently being received |
| in_rx | input | 1 | Radio is in receive |
| tx_req | input | 1 | Transmit request |
| quality_cnt | output | 5 | Current preamble score |
| quality_ok | output | 1 | Score has reached 4 × threshold |
| chan_clear | output | 1 | Channel judged clear by the selected policy |
| tx_grant | output | 1 | Transmit request honoured |

## Verification
The estimator is driven with a long alternating run. The run shows the +1 step and the saturation at 31. A run of identical bits after that walks the score down by 8 and into the floor at 0, which tells the two step sizes apart. Clears are issued on top of a valid bit, and then a bit opposite to the stale history is sent. This shows whether the history is really forgotten. The threshold compare is probed one count below and at the limit. All four policies are swept over every combination of the two channel indications, and the transmit gate is tried both inside and outside receive.

// File: rtl/lq_pkg.sv
package lq_pkg;
   typedef enum logic [1:0] {
      CC_ALWAYS = 2'd0,
      CC_QUIET  = 2'd1,
      CC_NOPKT  = 2'd2,
      CC_BOTH   = 2'd3
   } cc_mode_e;
endpackage

// File: rtl/lq_preamble_est.sv
module lq_preamble_est #(
   parameter int CNT_W     = 5,
   parameter int DOWN_STEP = 8,
   parameter int THR_W     = 3,
   parameter int THR_SCALE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             bit_valid,
   input  logic             bit_in,
   input  logic [THR_W-1:0] thr,
   output logic [CNT_W-1:0] cnt,
   output logic             reached
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;
   localparam int THR_MAX = (1 << THR_W) - 1;
   localparam logic [CNT_W-1:0] MAX_V  = CNT_W'(CNT_MAX);
   localparam logic [CNT_W-1:0] STEP_V = CNT_W'(DOWN_STEP);

   if (CNT_W < 2) begin : g_bad_w
      $error("lq_preamble_est: CNT_W must be at least 2");
   end
   if (DOWN_STEP < 1 || DOWN_STEP > CNT_MAX) begin : g_bad_step
      $error("lq_preamble_est: DOWN_STEP out of range");
   end
   if (THR_MAX * THR_SCALE > CNT_MAX) begin : g_bad_scale
      $error("lq_preamble_est: threshold scale exceeds counter range");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             prev_q;
   logic             have_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         prev_q <= 1'b0;
         have_q <= 1'b0;
      end else if (clr) begin
         cnt_q  <= '0;
         have_q <= 1'b0;
      end else if (bit_valid) begin
         prev_q <= bit_in;
         have_q <= 1'b1;
         if (have_q) begin
            if (bit_in != prev_q) begin
               cnt_q <= (cnt_q == MAX_V) ? cnt_q : cnt_q + 1'b1;
            end else begin
               cnt_q <= (cnt_q < STEP_V) ? '0 : cnt_q - STEP_V;
            end
         end
      end
   end

   logic [CNT_W:0] limit;
   assign limit   = (CNT_W+1)'(thr) * (CNT_W+1)'(THR_SCALE);
   assign reached = {1'b0, cnt_q} >= limit;
   assign cnt     = cnt_q;
endmodule

// File: rtl/lq_clear_chan.sv
module lq_clear_chan
   import lq_pkg::*;
#(
   parameter bit REGISTERED = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  cc_mode_e mode,
   input  logic     rssi_low,
   input  logic     pkt_active,
   output logic     clear
);
   logic raw;

   always_comb begin
      unique case (mode)
         CC_ALWAYS: raw = 1'b1;
         CC_QUIET:  raw = rssi_low;
         CC_NOPKT:  raw = !pkt_active;
         default:   raw = rssi_low && !pkt_active;
      endcase
   end

   if (REGISTERED) begin : g_reg
      logic clear_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) clear_q <= 1'b0;
         else        clear_q <= raw;
      end
      assign clear = clear_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign clear = raw;
   end
endmodule

// File: rtl/link_qualifier.sv
module link_qualifier
   import lq_pkg::*;
#(
   parameter int CNT_W     = 5,
   parameter int DOWN_STEP = 8,
   parameter int THR_W     = 3,
   parameter int THR_SCALE = 4,
   parameter bit CC_REG    = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rx_start,
   input  logic             sync_found,
   input  logic             bit_valid,
   input  logic             bit_in,
   input  logic             cfg_we,
   input  logic [THR_W-1:0] cfg_thr,
   input  logic [1:0]       cfg_mode,
   input  logic             rssi_low,
   input  logic             pkt_active,
   input  logic             in_rx,
   input  logic             tx_req,
   output logic [CNT_W-1:0] quality_cnt,
   output logic             quality_ok,
   output logic             chan_clear,
   output logic             tx_grant
);
   logic [THR_W-1:0] thr_q;
   cc_mode_e         mode_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr_q  <= '0;
         mode_q <= CC_BOTH;
      end else if (cfg_we) begin
         thr_q  <= cfg_thr;
         mode_q <= cc_mode_e'(cfg_mode);
      end
   end

   lq_preamble_est #(
      .CNT_W(CNT_W), .DOWN_STEP(DOWN_STEP), .THR_W(THR_W), .THR_SCALE(THR_SCALE)
   ) est_i (
      .clk(clk), .rst_n(rst_n), .clr(rx_start || sync_found),
      .bit_valid(bit_valid), .bit_in(bit_in), .thr(thr_q),
      .cnt(quality_cnt), .reached(quality_ok)
   );

   lq_clear_chan #(.REGISTERED(CC_REG)) cc_i (
      .clk(clk), .rst_n(rst_n), .mode(mode_q),
      .rssi_low(rssi_low), .pkt_active(pkt_active), .clear(chan_clear)
   );

   assign tx_grant = tx_req && (!in_rx || chan_clear);
endmodule

// File: rtl/link_qualifier_chk.sv
module link_qualifier_chk #(
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rx_start,
   input logic             sync_found,
   input logic             bit_valid,
   input logic [CNT_W-1:0] quality_cnt,
   input logic             quality_ok,
   input logic [2:0]       thr_q,
   input logic [1:0]       mode_q,
   input logic             chan_clear,
   input logic             in_rx,
   input logic             tx_req,
   input logic             tx_grant
);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   // R5: a clear leaves a zero score
   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_start || sync_found) |=> (quality_cnt == '0));

   // R9: no bit and no clear keeps the score
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid && !rx_start && !sync_found) |=> $stable(quality_cnt));

   // R2 / R3: a valid bit moves the score only by the allowed steps
   a_r2_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid && !rx_start && !sync_found) |=>
         ((int'(quality_cnt) == int'($past(quality_cnt)) + 1) ||
          (int'(quality_cnt) == CNT_MAX && int'($past(quality_cnt)) == CNT_MAX) ||
          (int'(quality_cnt) + 8 == int'($past(quality_cnt))) ||
          (quality_cnt == '0 && int'($past(quality_cnt)) < 8) ||
          (quality_cnt == $past(quality_cnt))));

   // R4: a zero threshold always reports quality reached
   a_r4_zero_thr: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q == 3'd0) |-> quality_ok);

   // R7: policy 0 is always clear
   a_r7_always_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'd0) |-> chan_clear);

   // R8: no grant without a request, and none in receive on a busy channel
   a_r8_grant_gate: assert property (@(posedge clk) disable iff (!rst_n)
      tx_grant |-> (tx_req && (!in_rx || chan_clear)));
endmodule

bind link_qualifier link_qualifier_chk #(.CNT_W(CNT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .sync_found(sync_found),
   .bit_valid(bit_valid), .quality_cnt(quality_cnt), .quality_ok(quality_ok),
   .thr_q(thr_q), .mode_q(mode_q), .chan_clear(chan_clear),
   .in_rx(in_rx), .tx_req(tx_req), .tx_grant(tx_grant)
);

// File: tb/link_qualifier_tb_top.sv
`timescale 1ns/1ps
module link_qualifier_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_start = 0, sync_found = 0, bit_valid = 0, bit_in = 0;
   logic cfg_we = 0;
   logic [2:0] cfg_thr = 0;
   logic [1:0] cfg_mode = 0;
   logic rssi_low = 0, pkt_active = 0, in_rx = 0, tx_req = 0;
   logic [4:0] quality_cnt;
   logic quality_ok, chan_clear, tx_grant;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   int exp_cnt = 0;
   logic exp_prev = 0;
   bit exp_have = 0;

   always #10 clk = ~clk;

   link_qualifier dut_i (
      .clk(clk), .rst_n(rst_n), .rx_start(rx_start), .sync_found(sync_found),
      .bit_valid(bit_valid), .bit_in(bit_in), .cfg_we(cfg_we), .cfg_thr(cfg_thr),
      .cfg_mode(cfg_mode), .rssi_low(rssi_low), .pkt_active(pkt_active),
      .in_rx(in_rx), .tx_req(tx_req), .quality_cnt(quality_cnt),
      .quality_ok(quality_ok), .chan_clear(chan_clear), .tx_grant(tx_grant)
   );

   task automatic check(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // called at a negedge; returns at the following negedge
   task automatic put_bit(logic b);
      bit_in = b;
      bit_valid = 1;
      @(negedge clk);
      bit_valid = 0;
      if (exp_have) begin
         if (b != exp_prev) exp_cnt = (exp_cnt == 31) ? 31 : exp_cnt + 1;
         else               exp_cnt = (exp_cnt < 8) ? 0 : exp_cnt - 8;
      end
      exp_prev = b;
      exp_have = 1;
   endtask

   task automatic write_cfg(logic [2:0] t, logic [1:0] m);
      cfg_thr = t; cfg_mode = m; cfg_we = 1;
      @(negedge clk);
      cfg_we = 0;
   endtask

   function automatic bit model_clear(int m, bit rl, bit pa);
      case (m)
         0: return 1;
         1: return rl;
         2: return !pa;
         default: return rl && !pa;
      endcase
   endfunction

   task automatic t_reset();
      check("R6 reset count", quality_cnt, 0);
      check("R4 reset thr 0 gives ok", quality_ok, 1);
      rssi_low = 1; pkt_active = 0; #2;
      check("R6 reset policy 3 quiet idle", chan_clear, 1);
      pkt_active = 1; #2;
      check("R6 reset policy 3 packet busy", chan_clear, 0);
      pkt_active = 0; rssi_low = 0;
      @(negedge clk);
   endtask

   task automatic t_first_bit();
      put_bit(1);
      check("R1 first bit not counted", quality_cnt, exp_cnt);
      check("R1 first bit exp zero", quality_cnt, 0);
   endtask

   task automatic t_alternate();
      for (int i = 0; i < 9; i++) put_bit(~exp_prev);
      check("R2 nine transitions", quality_cnt, 9);
      for (int i = 0; i < 30; i++) put_bit(~exp_prev);
      check("R2 saturate at 31", quality_cnt, 31);
      put_bit(~exp_prev);
      check("R2 stays at 31", quality_cnt, 31);
   endtask

   task automatic t_hold();
      repeat (5) @(negedge clk);
      check("R9 idle hold", quality_cnt, exp_cnt);
   endtask

   task automatic t_repeat();
      put_bit(exp_prev);
      check("R3 31 minus 8", quality_cnt, 23);
      put_bit(exp_prev);
      put_bit(exp_prev);
      check("R3 down to 7", quality_cnt, 7);
      put_bit(exp_prev);
      check("R3 floor at 0", quality_cnt, 0);
      put_bit(exp_prev);
      check("R3 stays at 0", quality_cnt, 0);
   endtask

   task automatic t_threshold();
      write_cfg(3'd3, 2'd3);
      for (int i = 0; i < 11; i++) put_bit(~exp_prev);
      check("R4 count 11", quality_cnt, 11);
      check("R4 below limit 12", quality_ok, 0);
      put_bit(~exp_prev);
      check("R4 at limit 12", quality_ok, 1);
      write_cfg(3'd7, 2'd3);
      check("R4 thr 7 needs 28", quality_ok, 0);
   endtask

   task automatic t_clear(bit use_sync);
      logic old_prev;
      for (int i = 0; i < 6; i++) put_bit(~exp_prev);
      old_prev = exp_prev;
      if (use_sync) sync_found = 1; else rx_start = 1;
      bit_in = ~old_prev; bit_valid = 1;
      @(negedge clk);
      sync_found = 0; rx_start = 0; bit_valid = 0;
      exp_cnt = 0; exp_have = 0;
      check(use_sync ? "R5 sync clears" : "R5 rx start clears", quality_cnt, 0);
      put_bit(~old_prev);
      check("R1 history forgotten after clear", quality_cnt, 0);
      put_bit(~exp_prev);
      check("R1 counting resumes", quality_cnt, 1);
   endtask

   task automatic t_cfg_ignore();
      write_cfg(3'd0, 2'd1);
      cfg_thr = 3'd7; cfg_mode = 2'd2;
      @(negedge clk);
      @(negedge clk);
      check("R6 thr kept without strobe", quality_ok, 1);
      rssi_low = 1; pkt_active = 1; #2;
      check("R6 policy kept without strobe", chan_clear, 1);
      rssi_low = 0; pkt_active = 0;
   endtask

   task automatic t_policies();
      for (int m = 0; m < 4; m++) begin
         write_cfg(3'd0, 2'(m));
         for (int c = 0; c < 4; c++) begin
            rssi_low = c[0]; pkt_active = c[1]; #2;
            check($sformatf("R7 policy %0d case %0d", m, c), chan_clear,
                  model_clear(m, c[0], c[1]));
         end
      end
      rssi_low = 0; pkt_active = 0;
      @(negedge clk);
   endtask

   task automatic t_tx_gate();
      write_cfg(3'd0, 2'd3);
      tx_req = 1; in_rx = 0; rssi_low = 0; pkt_active = 1; #2;
      check("R8 outside rx passes", tx_grant, 1);
      in_rx = 1; #2;
      check("R8 rx busy blocks", tx_grant, 0);
      rssi_low = 1; pkt_active = 0; #2;
      check("R8 rx clear grants", tx_grant, 1);
      tx_req = 0; #2;
      check("R8 no request no grant", tx_grant, 0);
      in_rx = 0; rssi_low = 0;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_first_bit();
      t_alternate();
      t_hold();
      t_repeat();
      t_threshold();
      t_clear(0);
      t_clear(1);
      t_cfg_ignore();
      t_policies();
      t_tx_gate();
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule